// File: doc/BRIEF.md
# Virtual Group-1 Interrupt Enable Access Controller

This block owns a single group-enable flag kept in three copies: one for a virtual machine, one for the secure physical side and one for the non-secure physical side. Every read or write request is judged against the requester's privilege level and a set of control bits. Those bits say which levels exist, which levels run the narrow (32-bit) execution state, and which trap, routing, register-enable and security-state settings apply.

Each request ends in exactly one of three kinds of result. It can be refused as undefined. It can be diverted as a trap toward a higher level, with the trap flavour encoded. Or it can be served from one chosen copy. The result is registered and appears one clock after the request strobe. Only a served write changes storage. The three stored flags are exported so that interrupt-signalling logic elsewhere can use them. Taking the exception itself is left to the surrounding core.

Top module: `vgen_access_ctrl`

## Requirements
- R1: The register is 32 bits wide. Only bit 0 is stored. A served read returns the stored bit in bit 0 and zeros in bits 31:1. Bits 31:1 of write data have no effect on any stored flag.
- R2: After reset all three stored flags are 0 and the `outcome`, `syndrome` and `rd_data` outputs are all zero.
- R3: A request made at level 0 (`cur_lvl`=0) gives the undefined outcome (`outcome`=6'h02).
- R4: At level 1 the checks are applied in this priority order, and the first one that matches decides the result:
  - with level 2 enabled, `cp_reg_trap` gives a level-2 trap;
  - a clear `sre_lvl1` gives undefined;
  - with level 2 enabled, `trap_all_g1` gives a level-2 trap;
  - with level 2 enabled, `virq_route` serves the virtual copy;
  - with level 3 present, `irq_to_lvl3` gives a level-3 trap;
  - otherwise a physical copy is served.
- R5: `outcome` bit positions are: 0 served, 1 undefined, 2 trap to a wide level 2, 3 hypervisor trap (level 2 narrow), 4 trap to a wide level 3, 5 monitor trap. Traps at bits 2, 3 and 4 report `syndrome`=6'h03. Every other outcome reports `syndrome`=0.
- R6: At level 1, when level 3 is narrow, `irq_to_lvl3` gives a monitor trap only while `monitor_mode` is 0. While `monitor_mode` is 1 the check is passed and a physical copy is served.
- R7: At level 1, a physical access with level 3 present uses the secure copy when `nonsecure`=0 and the non-secure copy when `nonsecure`=1. With level 3 absent, it uses the single physical copy, which is the non-secure storage.
- R8: At level 2 the checks are applied in this order:
  - a clear `sre_lvl2` gives undefined;
  - with level 3 present, `irq_to_lvl3` traps to level 3: a level-3 trap when level 3 is wide, and a monitor trap when it is narrow, whatever `monitor_mode` is;
  - otherwise the non-secure copy is served.
- R9: At level 3, a clear `sre_lvl3` gives undefined. Otherwise `nonsecure` selects the secure copy (0) or the non-secure copy (1).
- R10: Undefined and trapped requests leave all three flags unchanged and return `rd_data`=0.
- R11: `outcome` is one-hot in the cycle after a request strobe and all zero in the cycle after a cycle without a strobe. A served write updates its copy on that same clock edge.
- R12: `en_virt`, `en_sec` and `en_nsec` always show the current virtual, secure and non-secure stored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, one cycle per access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, only bit 0 used |
| cur_lvl | input | 2 | Privilege level of the requester (0..3) |
| lvl2_on | input | 1 | Level 2 implemented and enabled |
| lvl2_narrow | input | 1 | Level 2 runs the 32-bit execution state |
| lvl3_on | input | 1 | Level 3 implemented |
| lvl3_narrow | input | 1 | Level 3 runs the 32-bit execution state |
| monitor_mode | input | 1 | Processor currently in monitor mode |
| cp_reg_trap | input | 1 | Level-2 coprocessor-register trap control |
| sre_lvl1 | input | 1 | System-register interface enable seen at level 1 |
| sre_lvl2 | input | 1 | System-register interface enable seen at level 2 |
| sre_lvl3 | input | 1 | System-register interface enable seen at level 3 |
| trap_all_g1 | input | 1 | Trap all group-1 accesses to level 2 |
| virq_route | input | 1 | Interrupt routing override, selects the virtual copy |
| irq_to_lvl3 | input | 1 | IRQ routed to level 3 |
| nonsecure | input | 1 | Current security state is non-secure |
| rd_data | output | 32 | Registered read data |
| outcome | output | 6 | Registered one-hot outcome |
| syndrome | output | 6 | Registered trap syndrome code |
| en_virt | output | 1 | Virtual copy of the enable |
| en_sec | output | 1 | Secure physical copy of the enable |
| en_nsec | output | 1 | Non-secure physical copy of the enable |

## Verification
The level-1 chain is driven with several controls set at once, each time clearing the winning control. This shows that each check overrides the ones below it: register-enable over trap-all, and the virtual route over the level-3 routing trap. Each trap is repeated with the target level in both execution states, and at level 2 with `monitor_mode` set. This separates wide, hypervisor and monitor trap codes and confirms that the monitor-mode exemption applies only at level 1. Served writes go to each copy in turn, with full-ones and upper-bits-only data, and the exported flags are read back. This shows that the secure, non-secure and single-copy selections differ and that refused writes touch nothing.

// File: rtl/vgen_pkg.sv
package vgen_pkg;

    // Outcome kinds; each value is also the bit index in the one-hot outcome.
    typedef enum logic [2:0] {
        K_ACCESS   = 3'd0,
        K_UNDEF    = 3'd1,
        K_TRAP_L2W = 3'd2,
        K_TRAP_L2H = 3'd3,
        K_TRAP_L3W = 3'd4,
        K_TRAP_MON = 3'd5
    } kind_e;

    localparam int unsigned NUM_KINDS  = 6;
    localparam int unsigned NUM_COPIES = 3;

    typedef enum logic [1:0] {
        C_VIRT = 2'd0,
        C_SEC  = 2'd1,
        C_NSEC = 2'd2
    } copy_e;

    typedef struct packed {
        kind_e kind;
        copy_e copy;
    } verdict_t;

    function automatic logic carries_syndrome(kind_e k);
        return (k == K_TRAP_L2W) || (k == K_TRAP_L2H) || (k == K_TRAP_L3W);
    endfunction

endpackage

// File: rtl/vgen_dec_lvl1.sv
module vgen_dec_lvl1
    import vgen_pkg::*;
(
    input  logic     lvl2_on,
    input  logic     lvl2_narrow,
    input  logic     lvl3_on,
    input  logic     lvl3_narrow,
    input  logic     monitor_mode,
    input  logic     cp_reg_trap,
    input  logic     sre_lvl1,
    input  logic     trap_all_g1,
    input  logic     virq_route,
    input  logic     irq_to_lvl3,
    input  logic     nonsecure,
    output verdict_t verdict
);

    kind_e l2_trap;

    always_comb begin
        l2_trap = lvl2_narrow ? K_TRAP_L2H : K_TRAP_L2W;
        verdict = '{kind: K_ACCESS, copy: C_NSEC};
        if (lvl2_on && cp_reg_trap) begin
            verdict.kind = l2_trap;
        end else if (!sre_lvl1) begin
            verdict.kind = K_UNDEF;
        end else if (lvl2_on && trap_all_g1) begin
            verdict.kind = l2_trap;
        end else if (lvl2_on && virq_route) begin
            verdict.copy = C_VIRT;
        end else if (lvl3_on && irq_to_lvl3 && !lvl3_narrow) begin
            verdict.kind = K_TRAP_L3W;
        end else if (lvl3_on && irq_to_lvl3 && !monitor_mode) begin
            verdict.kind = K_TRAP_MON;
        end else if (lvl3_on) begin
            verdict.copy = nonsecure ? C_NSEC : C_SEC;
        end else begin
            verdict.copy = C_NSEC;  // single physical copy lives in non-secure storage
        end
    end

endmodule

// File: rtl/vgen_dec_upper.sv
module vgen_dec_upper
    import vgen_pkg::*;
(
    input  logic     at_lvl3,
    input  logic     sre_lvl2,
    input  logic     sre_lvl3,
    input  logic     lvl3_on,
    input  logic     lvl3_narrow,
    input  logic     irq_to_lvl3,
    input  logic     nonsecure,
    output verdict_t verdict
);

    always_comb begin
        verdict = '{kind: K_ACCESS, copy: C_NSEC};
        if (at_lvl3) begin
            if (!sre_lvl3) begin
                verdict.kind = K_UNDEF;
            end else begin
                verdict.copy = nonsecure ? C_NSEC : C_SEC;
            end
        end else begin
            if (!sre_lvl2) begin
                verdict.kind = K_UNDEF;
            end else if (lvl3_on && irq_to_lvl3) begin
                verdict.kind = lvl3_narrow ? K_TRAP_MON : K_TRAP_L3W;
            end else begin
                verdict.copy = C_NSEC;
            end
        end
    end

endmodule

// File: rtl/vgen_bank.sv
module vgen_bank
    import vgen_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  copy_e                 wr_sel,
    input  logic                  wr_bit,
    output logic [NUM_COPIES-1:0] flags
);

    logic [NUM_COPIES-1:0] flags_d;
    logic [NUM_COPIES-1:0] flags_q;

    for (genvar g = 0; g < NUM_COPIES; g++) begin : g_copy
        assign flags_d[g] = (wr_en && (int'(wr_sel) == g)) ? wr_bit : flags_q[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;

    // R10: without a served write no stored flag moves
    a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flags_q));

    // R11: a served write changes at most one copy
    a_r11_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $countones(flags_q ^ $past(flags_q)) <= 1);

endmodule

// File: rtl/vgen_access_ctrl.sv
module vgen_access_ctrl
    import vgen_pkg::*;
#(
    parameter int unsigned REG_W     = 32,
    parameter int unsigned SYND_W    = 6,
    parameter int unsigned SYND_TRAP = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 req_wr,
    input  logic [REG_W-1:0]     req_wdata,
    input  logic [1:0]           cur_lvl,
    input  logic                 lvl2_on,
    input  logic                 lvl2_narrow,
    input  logic                 lvl3_on,
    input  logic                 lvl3_narrow,
    input  logic                 monitor_mode,
    input  logic                 cp_reg_trap,
    input  logic                 sre_lvl1,
    input  logic                 sre_lvl2,
    input  logic                 sre_lvl3,
    input  logic                 trap_all_g1,
    input  logic                 virq_route,
    input  logic                 irq_to_lvl3,
    input  logic                 nonsecure,
    output logic [REG_W-1:0]     rd_data,
    output logic [NUM_KINDS-1:0] outcome,
    output logic [SYND_W-1:0]    syndrome,
    output logic                 en_virt,
    output logic                 en_sec,
    output logic                 en_nsec
);

    localparam logic [SYND_W-1:0] SYND_CODE = SYND_W'(SYND_TRAP);

    typedef struct packed {
        logic [NUM_KINDS-1:0] outcome;
        logic [SYND_W-1:0]    syndrome;
        logic [REG_W-1:0]     rd_data;
    } resp_t;

    verdict_t v_l1, v_up, v_sel;
    resp_t    resp_d, resp_q;
    logic [NUM_COPIES-1:0] flags;
    logic     sel_bit;
    logic     wr_en;
    logic     wdata_unused;

    assign wdata_unused = ^req_wdata[REG_W-1:1];

    vgen_dec_lvl1 u_dec_lvl1 (
        .lvl2_on      (lvl2_on),
        .lvl2_narrow  (lvl2_narrow),
        .lvl3_on      (lvl3_on),
        .lvl3_narrow  (lvl3_narrow),
        .monitor_mode (monitor_mode),
        .cp_reg_trap  (cp_reg_trap),
        .sre_lvl1     (sre_lvl1),
        .trap_all_g1  (trap_all_g1),
        .virq_route   (virq_route),
        .irq_to_lvl3  (irq_to_lvl3),
        .nonsecure    (nonsecure),
        .verdict      (v_l1)
    );

    vgen_dec_upper u_dec_upper (
        .at_lvl3     (cur_lvl == 2'd3),
        .sre_lvl2    (sre_lvl2),
        .sre_lvl3    (sre_lvl3),
        .lvl3_on     (lvl3_on),
        .lvl3_narrow (lvl3_narrow),
        .irq_to_lvl3 (irq_to_lvl3),
        .nonsecure   (nonsecure),
        .verdict     (v_up)
    );

    always_comb begin
        unique case (cur_lvl)
            2'd0:    v_sel = '{kind: K_UNDEF, copy: C_NSEC};
            2'd1:    v_sel = v_l1;
            default: v_sel = v_up;
        endcase

        case (v_sel.copy)
            C_VIRT:  sel_bit = flags[0];
            C_SEC:   sel_bit = flags[1];
            default: sel_bit = flags[2];
        endcase

        wr_en = req && req_wr && (v_sel.kind == K_ACCESS);

        resp_d = '0;
        if (req) begin
            resp_d.outcome[v_sel.kind] = 1'b1;
            if (carries_syndrome(v_sel.kind)) begin
                resp_d.syndrome = SYND_CODE;
            end
            if (!req_wr && (v_sel.kind == K_ACCESS)) begin
                resp_d.rd_data = {{(REG_W-1){1'b0}}, sel_bit};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    vgen_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (v_sel.copy),
        .wr_bit (req_wdata[0]),
        .flags  (flags)
    );

    assign rd_data  = resp_q.rd_data;
    assign outcome  = resp_q.outcome;
    assign syndrome = resp_q.syndrome;
    assign en_virt  = flags[0];
    assign en_sec   = flags[1];
    assign en_nsec  = flags[2];

    // R3: level-0 requests are refused
    a_r3_lvl0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cur_lvl == 2'd0) |=> outcome == NUM_KINDS'(1 << int'(K_UNDEF)));

    // R4: the coprocessor trap outranks every other level-1 check
    a_r4_cp_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cur_lvl == 2'd1 && lvl2_on && cp_reg_trap)
            |=> (outcome[K_TRAP_L2W] || outcome[K_TRAP_L2H]));

    // R9: level 3 with its interface disabled is refused
    a_r9_lvl3_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cur_lvl == 2'd3 && !sre_lvl3) |=> outcome[K_UNDEF]);

    // R11: one-hot after a strobe, silent otherwise
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> $onehot(outcome));
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> outcome == '0);

    // R5: syndrome only accompanies the trap kinds that carry one
    a_r5_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome[K_TRAP_L2W] || outcome[K_TRAP_L2H] || outcome[K_TRAP_L3W])
            |-> syndrome == SYND_CODE);

    // R10 / R1: refused results carry no data; upper bits never set
    a_r10_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        !outcome[K_ACCESS] |-> rd_data == '0);
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:1] == '0);

endmodule

// File: tb/vgen_access_ctrl_bench.sv
module vgen_access_ctrl_bench;

    localparam logic [5:0] O_ACC = 6'h01, O_UND = 6'h02, O_L2W = 6'h04,
                           O_L2H = 6'h08, O_L3W = 6'h10, O_MON = 6'h20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_wr = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  cur_lvl = 2'd0;
    logic lvl2_on, lvl2_narrow, lvl3_on, lvl3_narrow, monitor_mode;
    logic cp_reg_trap, sre_lvl1, sre_lvl2, sre_lvl3, trap_all_g1;
    logic virq_route, irq_to_lvl3, nonsecure;
    logic [31:0] rd_data;
    logic [5:0]  outcome, syndrome;
    logic en_virt, en_sec, en_nsec;

    int checks = 0, failures = 0;
    logic done = 1'b0;
    logic mv = 1'b0, ms = 1'b0, mn = 1'b0;

    always #4 clk = ~clk;

    vgen_access_ctrl u_vgen_access_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_wdata(req_wdata),
        .cur_lvl(cur_lvl), .lvl2_on(lvl2_on), .lvl2_narrow(lvl2_narrow),
        .lvl3_on(lvl3_on), .lvl3_narrow(lvl3_narrow), .monitor_mode(monitor_mode),
        .cp_reg_trap(cp_reg_trap), .sre_lvl1(sre_lvl1), .sre_lvl2(sre_lvl2),
        .sre_lvl3(sre_lvl3), .trap_all_g1(trap_all_g1), .virq_route(virq_route),
        .irq_to_lvl3(irq_to_lvl3), .nonsecure(nonsecure), .rd_data(rd_data),
        .outcome(outcome), .syndrome(syndrome), .en_virt(en_virt),
        .en_sec(en_sec), .en_nsec(en_nsec)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic defaults();
        lvl2_on = 1; lvl2_narrow = 0; lvl3_on = 1; lvl3_narrow = 0; monitor_mode = 0;
        cp_reg_trap = 0; sre_lvl1 = 1; sre_lvl2 = 1; sre_lvl3 = 1; trap_all_g1 = 0;
        virq_route = 0; irq_to_lvl3 = 0; nonsecure = 1;
    endtask

    // One request: drive at a falling edge, registered at the rising edge, sampled at the next falling edge.
    task automatic access(input logic [1:0] lvl, input logic wr, input logic [31:0] wd);
        @(negedge clk);
        cur_lvl = lvl; req = 1; req_wr = wr; req_wdata = wd;
        @(negedge clk);
        req = 0; req_wr = 0; req_wdata = '0;
    endtask

    task automatic expect_res(input string tag, input logic [5:0] o, input logic [5:0] s,
                              input logic [31:0] rd);
        chk({tag, " outcome"}, 32'(outcome), 32'(o));
        chk({tag, " syndrome"}, 32'(syndrome), 32'(s));
        chk({tag, " rd_data"}, rd_data, rd);
    endtask

    task automatic expect_en(input string tag);
        chk({tag, " R12 enables"}, {29'b0, en_virt, en_sec, en_nsec}, {29'b0, mv, ms, mn});
    endtask

    task automatic t_reset();
        expect_res("R2 reset", 6'h00, 6'h00, 32'h0);
        expect_en("R2 reset");
    endtask

    task automatic t_level0();
        defaults();
        access(2'd0, 1, 32'h1);
        expect_res("R3 lvl0 write", O_UND, 0, 0);
        expect_en("R10 lvl0 write");
        access(2'd0, 0, 0);
        expect_res("R3 R10 lvl0 read", O_UND, 0, 0);
    endtask

    task automatic t_level3();
        defaults();
        sre_lvl3 = 0;
        access(2'd3, 1, 32'h1);
        expect_res("R9 lvl3 sre off", O_UND, 0, 0);
        expect_en("R10 lvl3 undef");
        sre_lvl3 = 1; nonsecure = 0;
        access(2'd3, 1, 32'hFFFF_FFFF); ms = 1;
        expect_res("R9 lvl3 secure write", O_ACC, 0, 0);
        expect_en("R9 lvl3 secure write");
        access(2'd3, 0, 0);
        expect_res("R1 R9 read secure", O_ACC, 0, 32'h1);
        access(2'd3, 1, 32'hFFFF_FFFE); ms = 0;
        expect_en("R1 upper bits ignored");
        access(2'd3, 1, 32'h1); ms = 1;
        nonsecure = 1;
        access(2'd3, 1, 32'h1); mn = 1;
        expect_en("R9 lvl3 nonsecure write");
        access(2'd3, 0, 0);
        expect_res("R9 read nonsecure", O_ACC, 0, 32'h1);
    endtask

    task automatic t_idle();
        @(negedge clk);
        req = 0;
        @(negedge clk);
        expect_res("R11 idle", 6'h00, 0, 0);
    endtask

    task automatic t_level1();
        defaults();
        cp_reg_trap = 1; sre_lvl1 = 0;
        access(2'd1, 1, 32'h0);
        expect_res("R4 R5 cp trap wide", O_L2W, 6'h03, 0);
        expect_en("R10 cp trap");
        lvl2_narrow = 1;
        access(2'd1, 0, 0);
        expect_res("R5 R10 cp trap hyp", O_L2H, 6'h03, 0);
        lvl2_on = 0;
        access(2'd1, 0, 0);
        expect_res("R4 cp ignored with l2 off", O_UND, 0, 0);
        lvl2_on = 1; lvl2_narrow = 0; cp_reg_trap = 0; trap_all_g1 = 1;
        access(2'd1, 0, 0);
        expect_res("R4 sre before trap_all", O_UND, 0, 0);
        sre_lvl1 = 1; virq_route = 1;
        access(2'd1, 0, 0);
        expect_res("R4 trap_all before virq", O_L2W, 6'h03, 0);
        trap_all_g1 = 0; irq_to_lvl3 = 1;
        access(2'd1, 1, 32'h1); mv = 1;
        expect_res("R4 virq before irq trap", O_ACC, 0, 0);
        expect_en("R4 virtual write");
        access(2'd1, 0, 0);
        expect_res("R4 virtual read", O_ACC, 0, 32'h1);
        virq_route = 0;
        access(2'd1, 0, 0);
        expect_res("R4 R5 irq trap l3 wide", O_L3W, 6'h03, 0);
        lvl3_narrow = 1;
        access(2'd1, 0, 0);
        expect_res("R6 monitor trap", O_MON, 0, 0);
        monitor_mode = 1; nonsecure = 0;
        access(2'd1, 1, 32'h0); ms = 0;
        expect_res("R6 monitor mode passes", O_ACC, 0, 0);
        expect_en("R7 secure write lvl1");
        monitor_mode = 0; irq_to_lvl3 = 0; lvl2_on = 0; virq_route = 1; nonsecure = 1;
        access(2'd1, 1, 32'h0); mn = 0;
        expect_en("R4 R7 virq ignored l2 off");
        lvl3_on = 0; nonsecure = 0; irq_to_lvl3 = 1;
        access(2'd1, 1, 32'h1); mn = 1;
        expect_res("R7 single copy access", O_ACC, 0, 0);
        expect_en("R7 single copy is nonsecure");
    endtask

    task automatic t_level2();
        defaults();
        sre_lvl2 = 0;
        access(2'd2, 0, 0);
        expect_res("R8 sre off", O_UND, 0, 0);
        sre_lvl2 = 1; irq_to_lvl3 = 1;
        access(2'd2, 0, 0);
        expect_res("R8 irq trap wide", O_L3W, 6'h03, 0);
        lvl3_narrow = 1; monitor_mode = 1;
        access(2'd2, 1, 32'h0);
        expect_res("R8 monitor trap ignores mode", O_MON, 0, 0);
        expect_en("R10 lvl2 trap");
        irq_to_lvl3 = 0; nonsecure = 0;
        access(2'd2, 1, 32'h0); mn = 0;
        expect_en("R8 nonsecure copy regardless");
        lvl3_on = 0; irq_to_lvl3 = 1;
        access(2'd2, 1, 32'h1); mn = 1;
        expect_en("R8 no l3 single copy");
        access(2'd2, 0, 0);
        expect_res("R8 read", O_ACC, 0, 32'h1);
    endtask

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_level0();
        t_level3();
        t_idle();
        t_level1();
        t_level2();
        t_idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule